// File: doc/BRIEF.md
# Shared Interrupt Line Router

This block steers eight level-sensitive shared interrupt lines, named A to H, and one power-management interrupt onto a flat vector of 24 global interrupt outputs. Outputs 0 to 15 feed a legacy interrupt controller, and outputs 16 to 23 feed an advanced interrupt controller. Each shared line has a byte-wide route register. The register picks one legacy pin for the line, or turns off the line's legacy path. Several lines can share a legacy pin, and that pin is then the OR of all of them. On the advanced side every line has its own output, and this mapping cannot be changed.

A control byte picks which output carries the power-management interrupt. The choices are three legacy pins and two advanced pins. A select code that is not defined leaves the current choice in place. Software programs the route bytes and the control byte through a byte-wide write-only configuration port. The output vector is registered, so each output reflects the inputs and registers sampled at the previous clock edge.

Top module: `irq_router`

## Requirements
- R1: After reset, every output is 0, all eight route bytes hold 8'h80 (every legacy path disabled), and the power-management interrupt is routed to output 9.
- R2: Config addresses 0 to 7 write the route bytes of lines A to H. In a route byte, bits [3:0] give the legacy pin and bit 7 set disables the legacy path. Bits [6:4] have no effect.
- R3: Legacy output g (0 to 15) is the OR of every line whose route byte is enabled and names pin g.
- R4: Line n always drives output 16+n, whatever its route byte holds.
- R5: Config address 8 is the control byte. Its bits [2:0] select the power-management output: code 0 selects 9, code 1 selects 10, code 2 selects 11, code 4 selects 20, and code 5 selects 21. Bits [7:3] have no effect.
- R6: Writing reserved code 3, 6 or 7 leaves the current power-management selection unchanged.
- R7: The selected output carries the power-management level, ORed with any line routed to it. If the selection moves while that level is high, the old output drops in the same cycle that the new output rises, and no cycle shows both.
- R8: The power-management input is several bits wide. Any nonzero value counts as asserted, and zero counts as deasserted.
- R9: The outputs are registered. A change on a line or the power-management input appears after the next clock edge. A register write that is accepted on edge k appears after edge k+1.
- R10: Writes to config addresses 9 to 15 change no register and have no effect on the outputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfgWe | input | 1 | Configuration write strobe |
| cfgAddr | input | 4 | Configuration register address |
| cfgWrData | input | 8 | Configuration write data |
| lineIn | input | 8 | Shared interrupt line levels, bit 0 = line A |
| pmIn | input | 4 | Power-management interrupt level, nonzero = asserted |
| gsiOut | output | 24 | Global interrupt outputs: 0-15 legacy, 16-23 advanced |

## Verification
Two functions can act in the same cycle. The first is the move of the power-management selection. The second is the OR of shared lines onto legacy pins, and this includes the current or the new selected pin. The bench provokes the overlap in three ways. It moves the selection while the power-management level is high. It routes a shared line to the pin the selection is leaving, and to the pin it is entering. It changes a line level in the same cycle as a control write. The scoreboard predicts the whole 24-bit vector for every cycle, including the cycle of the write edge. A glitch, a late drop on the old pin, or a lost line level shows up as a mismatch on the exact cycle.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;

  localparam int unsigned NUM_LINES   = 8;
  localparam int unsigned LEGACY_PINS = 16;
  localparam int unsigned NUM_GSI     = LEGACY_PINS + NUM_LINES;
  localparam int unsigned GSI_IDX_W   = $clog2(NUM_GSI);
  localparam int unsigned PIN_W       = $clog2(LEGACY_PINS);
  localparam int unsigned DATA_W      = 8;
  localparam int unsigned ROUTE_DIS_BIT = 7;
  localparam int unsigned SEL_CODE_W  = 3;

  localparam logic [DATA_W-1:0]    ROUTE_RESET   = 8'h80;
  localparam logic [GSI_IDX_W-1:0] SEL_RESET_IDX = GSI_IDX_W'(9);

  // strobes from config decode to the datapath
  typedef struct packed {
    logic [NUM_LINES-1:0] routeWe;
    logic                 selWe;
    logic [GSI_IDX_W-1:0] selIdx;
    logic [DATA_W-1:0]    wrData;
  } cfgStrobe_t;

  typedef struct packed {
    logic                 legal;
    logic [GSI_IDX_W-1:0] idx;
  } selDecode_t;

  function automatic selDecode_t decodeSel(input logic [SEL_CODE_W-1:0] code);
    selDecode_t d;
    d.legal = 1'b1;
    d.idx   = SEL_RESET_IDX;
    case (code)
      3'd0: d.idx = GSI_IDX_W'(9);
      3'd1: d.idx = GSI_IDX_W'(10);
      3'd2: d.idx = GSI_IDX_W'(11);
      3'd4: d.idx = GSI_IDX_W'(20);
      3'd5: d.idx = GSI_IDX_W'(21);
      default: d.legal = 1'b0;
    endcase
    return d;
  endfunction

endpackage

// File: rtl/irq_router_ctrl.sv
module irq_router_ctrl
  import irq_router_pkg::*;
#(
  parameter int unsigned ADDR_W    = 4,
  parameter int unsigned CTRL_ADDR = NUM_LINES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfgWe,
  input  logic [ADDR_W-1:0] cfgAddr,
  input  logic [DATA_W-1:0] cfgWrData,
  output cfgStrobe_t        strobe
);

  selDecode_t selDec;
  logic [NUM_LINES-1:0] routeHit;

  always_comb selDec = decodeSel(cfgWrData[SEL_CODE_W-1:0]);

  for (genvar n = 0; n < NUM_LINES; n++) begin : g_route_dec
    assign routeHit[n] = cfgWe && (cfgAddr == ADDR_W'(n));
  end

  always_comb begin
    strobe.routeWe = routeHit;
    strobe.selWe   = cfgWe && (cfgAddr == ADDR_W'(CTRL_ADDR)) && selDec.legal;
    strobe.selIdx  = selDec.idx;
    strobe.wrData  = cfgWrData;
  end

  // R10: addresses above the control byte reach no register
  p_high_addr_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cfgAddr > ADDR_W'(CTRL_ADDR)) |-> (strobe.routeWe == '0 && !strobe.selWe));

  // R2: a write touches at most one register
  p_single_target_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({strobe.routeWe, strobe.selWe}));

  // R6: reserved codes never raise the select strobe
  p_reserved_no_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cfgWrData[SEL_CODE_W-1:0] inside {3'd3, 3'd6, 3'd7}) |-> !strobe.selWe);

endmodule

// File: rtl/irq_router_dp.sv
module irq_router_dp
  import irq_router_pkg::*;
#(
  parameter int unsigned PM_W = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  cfgStrobe_t           strobe,
  input  logic [NUM_LINES-1:0] lineIn,
  input  logic [PM_W-1:0]      pmIn,
  output logic [NUM_GSI-1:0]   gsiOut
);

  logic [DATA_W-1:0]      routeQ [NUM_LINES];
  logic [GSI_IDX_W-1:0]   selQ;
  logic [LEGACY_PINS-1:0] lineVec [NUM_LINES];
  logic [LEGACY_PINS-1:0] legacyOr;
  logic [NUM_GSI-1:0]     gsiNext;
  logic [NUM_LINES-1:0]   disBits;
  logic                   pmAct;

  assign pmAct = |pmIn;

  for (genvar n = 0; n < NUM_LINES; n++) begin : g_line
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 routeQ[n] <= ROUTE_RESET;
      else if (strobe.routeWe[n]) routeQ[n] <= strobe.wrData;
    end
    assign disBits[n] = routeQ[n][ROUTE_DIS_BIT];
    assign lineVec[n] = (lineIn[n] && !disBits[n])
                        ? (LEGACY_PINS'(1) << routeQ[n][PIN_W-1:0])
                        : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            selQ <= SEL_RESET_IDX;
    else if (strobe.selWe) selQ <= strobe.selIdx;
  end

  always_comb begin
    legacyOr = '0;
    for (int n = 0; n < NUM_LINES; n++) legacyOr |= lineVec[n];
    gsiNext = {lineIn, legacyOr};
    if (pmAct) gsiNext[selQ] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) gsiOut <= '0;
    else        gsiOut <= gsiNext;
  end

  // R4: every asserted line shows on its advanced output one cycle later
  p_adv_direct_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (lineIn != '0) |=> ((gsiOut[NUM_GSI-1:LEGACY_PINS] & $past(lineIn)) == $past(lineIn)));

  // R9: quiet inputs give a quiet vector on the next cycle
  p_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (lineIn == '0 && pmIn == '0) |=> (gsiOut == '0));

  // R3: with every legacy path disabled and no PM level, legacy pins stay low
  p_disabled_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((&disBits) && !pmAct) |=> (gsiOut[LEGACY_PINS-1:0] == '0));

  // R5: the selection is always one of the five decodable pins
  p_sel_legal_r5: assert property (@(posedge clk) disable iff (!rst_n)
    selQ inside {GSI_IDX_W'(9), GSI_IDX_W'(10), GSI_IDX_W'(11),
                 GSI_IDX_W'(20), GSI_IDX_W'(21)});

  // R6: without a select strobe the selection holds
  p_sel_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe.selWe |=> $stable(selQ));

  // R7/R8: a nonzero PM level shows on the selected output next cycle
  p_pm_on_sel_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pmAct |=> gsiOut[$past(selQ)]);

endmodule

// File: rtl/irq_router.sv
module irq_router
  import irq_router_pkg::*;
#(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned PM_W   = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfgWe,
  input  logic [ADDR_W-1:0]  cfgAddr,
  input  logic [7:0]         cfgWrData,
  input  logic [7:0]         lineIn,
  input  logic [PM_W-1:0]    pmIn,
  output logic [23:0]        gsiOut
);

  cfgStrobe_t strobe;

  irq_router_ctrl #(.ADDR_W(ADDR_W), .CTRL_ADDR(NUM_LINES)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfgWe    (cfgWe),
    .cfgAddr  (cfgAddr),
    .cfgWrData(cfgWrData),
    .strobe   (strobe)
  );

  irq_router_dp #(.PM_W(PM_W)) u_dp (
    .clk   (clk),
    .rst_n (rst_n),
    .strobe(strobe),
    .lineIn(lineIn),
    .pmIn  (pmIn),
    .gsiOut(gsiOut)
  );

endmodule

// File: tb/irq_router_tb.sv
module irq_router_tb;

  localparam time CLK_P = 10ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfgWe = 1'b0;
  logic [3:0]  cfgAddr = '0;
  logic [7:0]  cfgWrData = '0;
  logic [7:0]  lineIn = '0;
  logic [3:0]  pmIn = '0;
  logic [23:0] gsiOut;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [23:0] expQ[$];
  string       tagQ[$];

  logic [7:0] mRoute [8];
  int         mSel;

  always #(CLK_P/2) clk = ~clk;

  irq_router u_dut (
    .clk(clk), .rst_n(rst_n), .cfgWe(cfgWe), .cfgAddr(cfgAddr),
    .cfgWrData(cfgWrData), .lineIn(lineIn), .pmIn(pmIn), .gsiOut(gsiOut)
  );

  function automatic logic [23:0] model(input logic [7:0] lines, input logic [3:0] pm);
    logic [23:0] v = '0;
    for (int n = 0; n < 8; n++) begin
      v[16+n] = lines[n];
      if (lines[n] && !mRoute[n][7]) v[mRoute[n][3:0]] = 1'b1;
    end
    if (pm != 0) v[mSel] = 1'b1;
    return v;
  endfunction

  task automatic check(input logic [23:0] act, input logic [23:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // driver: one call per cycle, pushes the vector expected after the next edge
  task automatic drive(input logic [7:0] lines, input logic [3:0] pm, input logic we,
                       input logic [3:0] addr, input logic [7:0] data, input string tag);
    @(negedge clk);
    lineIn = lines; pmIn = pm; cfgWe = we; cfgAddr = addr; cfgWrData = data;
    expQ.push_back(model(lines, pm));
    tagQ.push_back(tag);
    if (we) begin
      if (addr < 8) mRoute[addr] = data;
      else if (addr == 8) begin
        case (data[2:0])
          3'd0: mSel = 9;
          3'd1: mSel = 10;
          3'd2: mSel = 11;
          3'd4: mSel = 20;
          3'd5: mSel = 21;
          default: ;
        endcase
      end
    end
  endtask

  task automatic idle(input logic [7:0] lines, input logic [3:0] pm, input string tag);
    drive(lines, pm, 1'b0, 4'd0, 8'd0, tag);
  endtask

  // monitor: compares queued expectations just after each edge
  initial begin
    forever begin
      @(posedge clk);
      #2;
      while (expQ.size() > 0) begin
        automatic logic [23:0] e = expQ.pop_front();
        automatic string t = tagQ.pop_front();
        check(gsiOut, e, t);
      end
    end
  end

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int n = 0; n < 8; n++) mRoute[n] = 8'h80;
    mSel = 9;
    repeat (3) @(posedge clk);
    #1;
    check(gsiOut, 24'h0, "R1 reset outputs");
    @(negedge clk);
    rst_n = 1'b1;

    // R1: reset routes disable every legacy path; R4 advanced still driven
    idle(8'hFF, 4'd0, "R1 routes disabled");
    idle(8'hFF, 4'd0, "R4 advanced direct");
    // R1: reset PM selection is pin 9
    idle(8'h00, 4'd1, "R1 pm default pin 9");

    // R2: route line A to pin 5, write visible one edge later (R9)
    drive(8'h01, 4'd0, 1'b1, 4'd0, 8'h05, "R9 write not early");
    idle(8'h01, 4'd0, "R2 line A to pin 5");
    // R2: bits 6:4 ignored, line B to pin 3
    drive(8'h03, 4'd0, 1'b1, 4'd1, 8'h73, "R9 write B pending");
    idle(8'h03, 4'd0, "R2 upper bits ignored");
    // R3: line C shares pin 5
    drive(8'h04, 4'd0, 1'b1, 4'd2, 8'h05, "R9 write C pending");
    idle(8'h05, 4'd0, "R3 shared pin both");
    idle(8'h04, 4'd0, "R3 shared pin C only");
    idle(8'h00, 4'd0, "R3 shared pin none");
    // R2: disable bit on A
    drive(8'h05, 4'd0, 1'b1, 4'd0, 8'h85, "R9 disable pending");
    idle(8'h05, 4'd0, "R2 disable bit");
    idle(8'h01, 4'd0, "R4 disabled line still advanced");

    // R5: each select code, with PM asserted
    drive(8'h00, 4'd1, 1'b1, 4'd8, 8'h01, "R7 old pin before move");
    idle(8'h00, 4'd1, "R5 code 1 pin 10");
    drive(8'h00, 4'd1, 1'b1, 4'd8, 8'hFA, "R5 code 2 pending");
    idle(8'h00, 4'd1, "R5 code 2 pin 11 upper bits ignored");
    drive(8'h00, 4'd1, 1'b1, 4'd8, 8'h04, "R5 code 4 pending");
    idle(8'h00, 4'd1, "R5 code 4 pin 20");
    drive(8'h00, 4'd1, 1'b1, 4'd8, 8'h05, "R5 code 5 pending");
    idle(8'h00, 4'd1, "R5 code 5 pin 21");
    // R6: reserved codes hold
    drive(8'h00, 4'd1, 1'b1, 4'd8, 8'h03, "R6 code 3");
    idle(8'h00, 4'd1, "R6 code 3 held");
    drive(8'h00, 4'd1, 1'b1, 4'd8, 8'h06, "R6 code 6");
    idle(8'h00, 4'd1, "R6 code 6 held");
    drive(8'h00, 4'd1, 1'b1, 4'd8, 8'h0F, "R6 code 7");
    idle(8'h00, 4'd1, "R6 code 7 held");
    // R8: other nonzero PM values
    idle(8'h00, 4'd8, "R8 pm 8 asserted");
    idle(8'h00, 4'd0, "R8 pm zero");
    idle(8'h00, 4'hF, "R8 pm F asserted");

    // R7: line D on pin 9 while PM moves from 21 to 9 and then away
    drive(8'h08, 4'd2, 1'b1, 4'd3, 8'h09, "R7 route D pending");
    drive(8'h08, 4'd2, 1'b1, 4'd8, 8'h00, "R7 move to 9 pending");
    idle(8'h08, 4'd2, "R7 pm and line share pin 9");
    drive(8'h00, 4'd2, 1'b1, 4'd8, 8'h01, "R7 line change with move");
    idle(8'h00, 4'd2, "R7 moved to 10 atomically");
    drive(8'h08, 4'd0, 1'b1, 4'd8, 8'h00, "R7 move while low");
    idle(8'h00, 4'd4, "R7 pm on 9 after move");

    // R10: writes to 9..15 ignored
    for (int a = 9; a < 16; a++) drive(8'hFF, 4'd0, 1'b1, a[3:0], 8'h02, "R10 high addr write");
    idle(8'hFF, 4'd4, "R10 routes and select unchanged");
    idle(8'h00, 4'd0, "R9 quiet");
    idle(8'h00, 4'd0, "R9 quiet hold");

    repeat (3) @(posedge clk);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule